// File: doc/BRIEF.md
# Dual-Rail Reset Supervisor Controller

This block watches two supply rails, one nominally 5 V and one nominally 3.3 V, and drives a separate reset output for each rail. Each rail arrives as a millivolt sample code with a valid strobe. The block keeps a per-rail "low" flag and updates it on every strobed sample. A tolerance-select input per rail picks between a tight trip threshold and a wide one.

Each rail has its own reset channel. A channel holds its reset while the rail is low. When the cause clears, the channel keeps the reset asserted for a stretch time and then releases it.

An active-low pushbutton input is synchronised and debounced inside the block. A press that stays low for the whole debounce window forces both resets. The block accepts a press only if at least one reset is released when the window completes. Both stretch and debounce lengths are cycle counts derived from a clock-frequency parameter. Output polarity is a build parameter.

Each reset channel is a three-state machine:
- HOLD: the cause is present. When the cause clears, the machine moves to STRETCH.
- STRETCH: the counter runs. If the cause returns, the machine goes back to HOLD. When the counter finishes, the machine moves to RUN.
- RUN: the reset is released. If the cause appears, the machine moves to HOLD.

The reset output is asserted in HOLD and in STRETCH.

The pushbutton is a four-state machine:
- IDLE: moves to COUNT when the synchronised button reads low.
- COUNT: goes back to IDLE if the button rises. When the window completes, it moves to FORCE if the press is accepted, or to IGNORE if it is not.
- FORCE: forces both resets. It moves to IDLE when the button rises.
- IGNORE: has no effect on the resets. It moves to IDLE when the button rises.

Top module: `dual_rail_supervisor`

## Requirements
- R1: On a strobed 5 V sample, the 5 V rail counts as low when the code is strictly below 4630 mV with its select at 0 (tight), or strictly below 4380 mV with its select at 1 (wide).
- R2: On a strobed 3.3 V sample, the 3.3 V rail counts as low when the code is strictly below 2880 mV with its select at 0 (tight), or strictly below 2550 mV with its select at 1 (wide).
- R3: A low rail asserts only its own reset. The other rail's reset is unaffected.
- R4: When a reset's cause clears, that reset stays asserted for STRETCH_MS milliseconds of clock cycles and then deasserts.
- R5: If the cause returns during the stretch, the stretch restarts and is measured from the last time the cause cleared.
- R6: A button low pulse shorter than DEBOUNCE_MS milliseconds of clock cycles has no effect on either reset.
- R7: Each tolerance select affects only its own rail's threshold.
- R8: An accepted press asserts both resets. They stay asserted while the button is held, and for the stretch time after it rises.
- R9: A press whose debounce window completes while both resets are asserted is ignored until the button rises.
- R10: With ACTIVE_LOW=1, an asserted reset output reads 0. With ACTIVE_LOW=0, an asserted reset output reads 1.
- R11: The synchronous reset asserts both outputs and marks both rails low. After the reset is released, each output stays asserted until a good sample arrives and its stretch has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rail5_mv | input | 13 | 5 V rail sample in millivolts |
| rail5_vld | input | 1 | Strobe marking a valid 5 V sample |
| rail5_wide | input | 1 | 5 V tolerance select: 0 tight, 1 wide |
| rail33_mv | input | 13 | 3.3 V rail sample in millivolts |
| rail33_vld | input | 1 | Strobe marking a valid 3.3 V sample |
| rail33_wide | input | 1 | 3.3 V tolerance select: 0 tight, 1 wide |
| btn_n | input | 1 | Pushbutton, active low, asynchronous |
| rst5_out | output | 1 | 5 V rail reset, polarity per ACTIVE_LOW |
| rst33_out | output | 1 | 3.3 V rail reset, polarity per ACTIVE_LOW |

## Verification
The bench drives each threshold to exactly its trip code and to one millivolt below it, under both selects. A comparator that used "less or equal" would then trip at the threshold itself, and swapped selects would trip the wrong rail.

It re-faults a rail partway through its stretch and checks that the reset is still held near the end of the original window. A design that did not reload the counter would release early.

A short button pulse must leave both resets released, which exposes a missing debounce. A press made while both rails are low must not extend the resets once the rails recover. A design that acted on that press would hold the resets until the button was released.

// File: rtl/rail_sup_pkg.sv
package rail_sup_pkg;
    localparam int MV_W = 13;

    typedef enum logic [1:0] {
        CH_HOLD,
        CH_STRETCH,
        CH_RUN
    } chan_state_e;

    typedef enum logic [1:0] {
        BT_IDLE,
        BT_COUNT,
        BT_FORCE,
        BT_IGNORE
    } btn_state_e;
endpackage

// File: rtl/rail_trip_cmp.sv
module rail_trip_cmp
    import rail_sup_pkg::*;
#(
    parameter int TH_TIGHT = 4630,
    parameter int TH_WIDE  = 4380
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [MV_W-1:0] sample_mv,
    input  logic            sample_vld,
    input  logic            wide_sel,
    output logic            rail_low
);
    localparam logic [MV_W-1:0] TIGHT_CODE = MV_W'(TH_TIGHT);
    localparam logic [MV_W-1:0] WIDE_CODE  = MV_W'(TH_WIDE);

    logic [MV_W-1:0] trip_code;

    always_comb trip_code = wide_sel ? WIDE_CODE : TIGHT_CODE;

    always_ff @(posedge clk) begin
        if (rst)
            rail_low <= 1'b1;
        else if (sample_vld)
            rail_low <= (sample_mv < trip_code);
    end
endmodule

// File: rtl/btn_qualifier.sv
module btn_qualifier
    import rail_sup_pkg::*;
#(
    parameter int DEB_CYC = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_n,
    input  logic accept,
    output logic force_o
);
    localparam int CW = $clog2(DEB_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

    logic [1:0]  sync_q;
    logic        btn_low;
    logic [CW-1:0] cnt_q;
    btn_state_e  state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst)
            sync_q <= 2'b11;
        else
            sync_q <= {sync_q[0], btn_n};
    end

    always_comb btn_low = ~sync_q[1];

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= BT_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BT_IDLE:   if (btn_low) state_d = BT_COUNT;
            BT_COUNT: begin
                if (!btn_low)
                    state_d = BT_IDLE;
                else if (cnt_q == LAST)
                    state_d = accept ? BT_FORCE : BT_IGNORE;
            end
            BT_FORCE:  if (!btn_low) state_d = BT_IDLE;
            BT_IGNORE: if (!btn_low) state_d = BT_IDLE;
            default:   state_d = BT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || state_q != BT_COUNT)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    always_comb force_o = (state_q == BT_FORCE);
endmodule

// File: rtl/reset_stretch.sv
module reset_stretch
    import rail_sup_pkg::*;
#(
    parameter int STR_CYC = 17500000
) (
    input  logic clk,
    input  logic rst,
    input  logic cause,
    output logic asserted
);
    localparam int CW = $clog2(STR_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(STR_CYC - 1);

    chan_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= CH_HOLD;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_HOLD:    if (!cause) state_d = CH_STRETCH;
            CH_STRETCH: begin
                if (cause)
                    state_d = CH_HOLD;
                else if (cnt_q == LAST)
                    state_d = CH_RUN;
            end
            CH_RUN:     if (cause) state_d = CH_HOLD;
            default:    state_d = CH_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || state_q != CH_STRETCH)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    always_comb asserted = (state_q != CH_RUN);
endmodule

// File: rtl/dual_rail_supervisor.sv
module dual_rail_supervisor
    import rail_sup_pkg::*;
#(
    parameter int CLK_HZ      = 50000000,
    parameter int STRETCH_MS  = 350,
    parameter int DEBOUNCE_MS = 2,
    parameter int TH5_TIGHT   = 4630,
    parameter int TH5_WIDE    = 4380,
    parameter int TH33_TIGHT  = 2880,
    parameter int TH33_WIDE   = 2550,
    parameter bit ACTIVE_LOW  = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [MV_W-1:0] rail5_mv,
    input  logic            rail5_vld,
    input  logic            rail5_wide,
    input  logic [MV_W-1:0] rail33_mv,
    input  logic            rail33_vld,
    input  logic            rail33_wide,
    input  logic            btn_n,
    output logic            rst5_out,
    output logic            rst33_out
);
    localparam int CYC_PER_MS = CLK_HZ / 1000;
    localparam int STR_CYC    = CYC_PER_MS * STRETCH_MS;
    localparam int DEB_CYC    = CYC_PER_MS * DEBOUNCE_MS;
    localparam int NRAIL      = 2;

    logic [NRAIL-1:0] rail_low;
    logic [NRAIL-1:0] cause;
    logic [NRAIL-1:0] asrt;
    logic [NRAIL-1:0] pin;
    logic             force_both;
    logic             accept;

    rail_trip_cmp #(.TH_TIGHT(TH5_TIGHT), .TH_WIDE(TH5_WIDE)) u_cmp5 (
        .clk(clk), .rst(rst), .sample_mv(rail5_mv), .sample_vld(rail5_vld),
        .wide_sel(rail5_wide), .rail_low(rail_low[0])
    );

    rail_trip_cmp #(.TH_TIGHT(TH33_TIGHT), .TH_WIDE(TH33_WIDE)) u_cmp33 (
        .clk(clk), .rst(rst), .sample_mv(rail33_mv), .sample_vld(rail33_vld),
        .wide_sel(rail33_wide), .rail_low(rail_low[1])
    );

    always_comb accept = ~(&asrt);

    btn_qualifier #(.DEB_CYC(DEB_CYC)) u_btn (
        .clk(clk), .rst(rst), .btn_n(btn_n), .accept(accept), .force_o(force_both)
    );

    for (genvar g = 0; g < NRAIL; g++) begin : g_chan
        always_comb cause[g] = rail_low[g] | force_both;

        reset_stretch #(.STR_CYC(STR_CYC)) u_str (
            .clk(clk), .rst(rst), .cause(cause[g]), .asserted(asrt[g])
        );

        if (ACTIVE_LOW) begin : g_low
            always_comb pin[g] = ~asrt[g];
        end else begin : g_high
            always_comb pin[g] = asrt[g];
        end
    end

    always_comb begin
        rst5_out  = pin[0];
        rst33_out = pin[1];
    end
endmodule

// File: rtl/rail_sup_chk.sv
module rail_sup_chk
    import rail_sup_pkg::*;
#(
    parameter int TH5_TIGHT  = 4630,
    parameter int TH5_WIDE   = 4380,
    parameter int TH33_TIGHT = 2880,
    parameter int TH33_WIDE  = 2550
) (
    input logic            clk,
    input logic            rst,
    input logic [MV_W-1:0] rail5_mv,
    input logic            rail5_vld,
    input logic            rail5_wide,
    input logic [MV_W-1:0] rail33_mv,
    input logic            rail33_vld,
    input logic            rail33_wide,
    input logic [1:0]      asrt,
    input logic [1:0]      cause,
    input logic            force_both
);
    logic [MV_W-1:0] thr5, thr33;
    always_comb begin
        thr5  = rail5_wide  ? MV_W'(TH5_WIDE)  : MV_W'(TH5_TIGHT);
        thr33 = rail33_wide ? MV_W'(TH33_WIDE) : MV_W'(TH33_TIGHT);
    end

    // R11
    reset_asserts_chk: assert property (@(posedge clk)
        rst |=> (asrt[0] && asrt[1]));

    // R1
    low5_trips_chk: assert property (@(posedge clk) disable iff (rst)
        (rail5_vld && rail5_mv < thr5) |=> ##1 asrt[0]);

    // R2
    low33_trips_chk: assert property (@(posedge clk) disable iff (rst)
        (rail33_vld && rail33_mv < thr33) |=> ##1 asrt[1]);

    // R8
    force_both_chk: assert property (@(posedge clk) disable iff (rst)
        force_both |=> (asrt[0] && asrt[1]));

    // R4
    release5_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(asrt[0]) |-> $past(!cause[0]));

    // R4
    release33_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(asrt[1]) |-> $past(!cause[1]));
endmodule

bind dual_rail_supervisor rail_sup_chk #(
    .TH5_TIGHT(TH5_TIGHT), .TH5_WIDE(TH5_WIDE),
    .TH33_TIGHT(TH33_TIGHT), .TH33_WIDE(TH33_WIDE)
) u_chk (
    .clk(clk), .rst(rst),
    .rail5_mv(rail5_mv), .rail5_vld(rail5_vld), .rail5_wide(rail5_wide),
    .rail33_mv(rail33_mv), .rail33_vld(rail33_vld), .rail33_wide(rail33_wide),
    .asrt(asrt), .cause(cause), .force_both(force_both)
);

// File: tb/test_dual_rail_supervisor.sv
`timescale 1ns/1ps
module test_dual_rail_supervisor;
    localparam int CLK_HZ = 10000;
    localparam int STR    = CLK_HZ / 1000 * 350;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] v5 = 13'd0, v33 = 13'd0;
    logic        v5_vld = 1'b0, v33_vld = 1'b0;
    logic        w5 = 1'b0, w33 = 1'b0;
    logic        btn_n = 1'b1;
    logic        o5, o33, h5, h33;
    int          total = 0, bad = 0;

    always #2 clk = ~clk;

    dual_rail_supervisor #(.CLK_HZ(CLK_HZ)) i_dual_rail_supervisor (
        .clk(clk), .rst(rst), .rail5_mv(v5), .rail5_vld(v5_vld), .rail5_wide(w5),
        .rail33_mv(v33), .rail33_vld(v33_vld), .rail33_wide(w33),
        .btn_n(btn_n), .rst5_out(o5), .rst33_out(o33)
    );

    dual_rail_supervisor #(.CLK_HZ(CLK_HZ), .ACTIVE_LOW(1'b0)) i_dual_rail_supervisor_hi (
        .clk(clk), .rst(rst), .rail5_mv(v5), .rail5_vld(v5_vld), .rail5_wide(w5),
        .rail33_mv(v33), .rail33_vld(v33_vld), .rail33_wide(w33),
        .btn_n(btn_n), .rst5_out(h5), .rst33_out(h33)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // expected asserted state per rail; active-low: asserted means 0 (R10)
    task automatic expect_rst(input string req, input bit e5, input bit e33);
        total++;
        if (o5 !== ~e5 || o33 !== ~e33) begin
            bad++;
            $display("FAIL %s: low-variant outs act=%b%b exp=%b%b", req, o5, o33, ~e5, ~e33);
        end
        total++;
        if (h5 !== e5 || h33 !== e33) begin
            bad++;
            $display("FAIL R10 (%s): high-variant outs act=%b%b exp=%b%b", req, h5, h33, e5, e33);
        end
    endtask

    task automatic set5(input int mv);
        @(negedge clk); v5 = 13'(mv); v5_vld = 1'b1;
        @(negedge clk); v5_vld = 1'b0;
    endtask

    task automatic set33(input int mv);
        @(negedge clk); v33 = 13'(mv); v33_vld = 1'b1;
        @(negedge clk); v33_vld = 1'b0;
    endtask

    task automatic t_reset();
        wait_cyc(5);
        expect_rst("R11 in reset", 1, 1);
        @(negedge clk); rst = 1'b0;
        wait_cyc(20);
        expect_rst("R11 no sample yet", 1, 1);
        set5(5000); set33(3300);
        wait_cyc(STR - 100);
        expect_rst("R4 power-up stretch held", 1, 1);
        wait_cyc(200);
        expect_rst("R4 power-up released", 0, 0);
    endtask

    task automatic t_thr5();
        w5 = 1'b0;
        set5(4630); wait_cyc(5);
        expect_rst("R1 tight at threshold", 0, 0);
        set5(4629); wait_cyc(5);
        expect_rst("R1 R3 tight below", 1, 0);
        set5(5000); wait_cyc(STR + 100);
        expect_rst("R4 5V recovered", 0, 0);
        w5 = 1'b1;
        set5(4500); wait_cyc(5);
        expect_rst("R1 wide 4500 ok", 0, 0);
        set5(4380); wait_cyc(5);
        expect_rst("R1 wide at threshold", 0, 0);
        set5(4379); wait_cyc(5);
        expect_rst("R1 wide below", 1, 0);
        set5(5000); wait_cyc(STR + 100);
        expect_rst("R4 5V recovered wide", 0, 0);
    endtask

    task automatic t_thr33();
        w33 = 1'b0;
        set33(2880); wait_cyc(5);
        expect_rst("R2 tight at threshold", 0, 0);
        set33(2879); wait_cyc(5);
        expect_rst("R2 R3 tight below", 0, 1);
        set33(3300); wait_cyc(STR + 100);
        expect_rst("R4 3V3 recovered", 0, 0);
        set5(4400); wait_cyc(5);
        expect_rst("R7 5V wide kept with 3V3 tight", 0, 0);
        set5(5000);
        w33 = 1'b1; w5 = 1'b0;
        set5(4600); wait_cyc(5);
        expect_rst("R7 5V tight with 3V3 wide", 1, 0);
        set5(5000); wait_cyc(STR + 100);
        set33(2550); wait_cyc(5);
        expect_rst("R2 wide at threshold", 0, 0);
        set33(2549); wait_cyc(5);
        expect_rst("R2 wide below", 0, 1);
        set33(3300); wait_cyc(STR + 100);
        expect_rst("R4 3V3 recovered wide", 0, 0);
    endtask

    task automatic t_reload();
        set5(4000); wait_cyc(5);
        set5(5000); wait_cyc(2000);
        expect_rst("R5 mid stretch", 1, 0);
        set5(4000); wait_cyc(5);
        set5(5000); wait_cyc(STR - 100);
        expect_rst("R5 stretch restarted", 1, 0);
        wait_cyc(200);
        expect_rst("R5 released after restart", 0, 0);
    endtask

    task automatic t_bounce();
        @(negedge clk); btn_n = 1'b0;
        for (int i = 0; i < 10; i++) begin
            wait_cyc(1);
            expect_rst("R6 short pulse", 0, 0);
        end
        @(negedge clk); btn_n = 1'b1;
        wait_cyc(40);
        expect_rst("R6 after short pulse", 0, 0);
    endtask

    task automatic t_press();
        @(negedge clk); btn_n = 1'b0;
        wait_cyc(40);
        expect_rst("R8 press asserts both", 1, 1);
        wait_cyc(1000);
        expect_rst("R8 held", 1, 1);
        @(negedge clk); btn_n = 1'b1;
        wait_cyc(STR - 100);
        expect_rst("R8 stretch after release", 1, 1);
        wait_cyc(200);
        expect_rst("R8 released", 0, 0);
    endtask

    task automatic t_ignore();
        set5(4000); set33(2000); wait_cyc(5);
        expect_rst("R9 both rails low", 1, 1);
        @(negedge clk); btn_n = 1'b0;
        wait_cyc(50);
        set5(5000); set33(3300);
        wait_cyc(STR + 100);
        expect_rst("R9 press ignored", 0, 0);
        @(negedge clk); btn_n = 1'b1;
        wait_cyc(50);
        expect_rst("R9 after release", 0, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_thr5();
                t_thr33();
                t_reload();
                t_bounce();
                t_press();
                t_ignore();
            end
            begin
                repeat (190000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: act=timeout exp=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule